// File: doc/BRIEF.md
# Staged Integer Clock Divider with Relock Status

This block is a three-stage integer divider chain, driven by a 32-bit register bus. It stands in for the counting part of a clock generator. Each stage has its own configuration word. The stages are a reference predivider, a loop divider and a post divider. Each word holds two 6-bit phase counts (high and low), a half-cycle alignment flag and a pass-through flag. It also holds a hold flag, which lets software stage a setting without applying it.

The stages run on the system clock as a chain of strobes. The first stage sees a strobe on every cycle. Each later stage advances only when the stage before it starts a new period. The waveform of the last stage is the divided output.

A write with the hold flag clear commits every staged word at the same time and restarts all stage counters. The same commit drops a lock status bit for a fixed number of cycles, so software can poll until the new setting has settled. A read-only ratio word reports the effective division of each committed stage.

Top module: `cdiv_top`

## Requirements
- R1: Registers are word-addressed by offset: 0x0 is the predivider, 0x4 the loop divider, 0x8 the post divider, 0xC the ratio word and 0x10 the status word. Each divider word holds the low count in bits 5:0, the high count in bits 11:6, the alignment flag in bit 12, the pass-through flag in bit 13 and the hold flag in bit 14. A read returns the committed value on `bus_rdata` one clock after the address is presented. The hold bit and all bits above it read as zero, and unmapped offsets read as zero.
- R2: After reset, every stage is in pass-through (each divider reads 0x00002000), the ratio word reads 0x00010101, the status word reads 1 and `div_out` is 1.
- R3: A non-bypassed stage with an even setting (low = high = N/2, alignment 0) yields a waveform that is high for N/2 strobes and low for N/2 strobes.
- R4: An odd setting (low = (N>>1)+1, high = N>>1, alignment 1) yields a waveform that is high for `high` strobes and low for `low` strobes. `half_adj` equals the committed alignment flag of the post divider when that stage is not bypassed.
- R5: A stage with the pass-through flag set forwards its input strobe unchanged, both as its waveform and as its period strobe.
- R6: A divider write with the hold flag set changes neither the committed words, nor the output waveform, nor the status bit.
- R7: A divider write with the hold flag clear commits all three staged words at once, including words staged earlier with hold set.
- R8: After a commit, the status bit reads 0 and first reads 1 again LOCK_CYC+1 clocks after the commit edge (LOCK_CYC = 16 by default).
- R9: A commit made while the status bit is 0 restarts the full unlock interval.
- R10: A high or low count of zero on a non-bypassed stage behaves as a count of one, both in the waveform and in the ratio word.
- R11: The ratio word holds the effective division (low + high, or 1 when bypassed) of the predivider in bits 7:0, of the loop divider in bits 15:8 and of the post divider in bits 23:16.
- R12: A stage advances only on the period strobes of the stage before it, so the output run lengths are the product of the chained ratios.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| div_out | output | 1 | Divided waveform of the post divider |
| half_adj | output | 1 | Half-cycle alignment request for a downstream stage |

## Verification
A wrong staged or committed word shows up on the read port one clock after the address is presented. On `div_out` it shows up within a single output period, as run lengths that differ from the commanded high and low counts. A lock counter that is loaded with the wrong value, or that ignores a restart, moves the first 1 on the status read away from cycle LOCK_CYC+1. A broken strobe chain stretches or shortens the output runs by the factor of the upstream stage, so the chained case catches it within one period.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    localparam int CNT_W     = 6;
    localparam int DATA_W    = 32;
    localparam int N_STAGES  = 3;
    localparam int RSVD_W    = DATA_W - 3 - 2 * CNT_W;
    localparam int RATIO_W   = CNT_W + 1;
    localparam int LANE_W    = 8;

    // Bus-visible divider word, bit 0 upward: low, high, align, bypass, hold.
    typedef struct packed {
        logic [RSVD_W-1:0] rsvd;
        logic              hold;
        logic              bypass;
        logic              align;
        logic [CNT_W-1:0]  hi_cnt;
        logic [CNT_W-1:0]  lo_cnt;
    } div_word_t;

    // Committed configuration carried to a stage.
    typedef struct packed {
        logic              bypass;
        logic              align;
        logic [CNT_W-1:0]  hi_cnt;
        logic [CNT_W-1:0]  lo_cnt;
    } div_cfg_t;

    typedef enum logic [2:0] {
        SEL_PRE   = 3'd0,
        SEL_LOOP  = 3'd1,
        SEL_POST  = 3'd2,
        SEL_RATIO = 3'd3,
        SEL_STAT  = 3'd4,
        SEL_NONE  = 3'd7
    } reg_sel_e;

    localparam div_cfg_t CFG_RESET = '{bypass: 1'b1, align: 1'b0,
                                       hi_cnt: '0, lo_cnt: '0};

    function automatic div_cfg_t word_to_cfg(input logic [DATA_W-1:0] raw);
        div_word_t w;
        div_cfg_t  c;
        w        = div_word_t'(raw);
        c.bypass = w.bypass;
        c.align  = w.align;
        c.hi_cnt = w.hi_cnt;
        c.lo_cnt = w.lo_cnt;
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_word(input div_cfg_t c);
        div_word_t w;
        w        = '0;
        w.bypass = c.bypass;
        w.align  = c.align;
        w.hi_cnt = c.hi_cnt;
        w.lo_cnt = c.lo_cnt;
        return DATA_W'(w);
    endfunction

    // Zero counts are promoted to one so a stage can never stall.
    function automatic logic [CNT_W-1:0] eff_len(input logic [CNT_W-1:0] n);
        return (n == '0) ? CNT_W'(1) : n;
    endfunction

    function automatic logic [RATIO_W-1:0] eff_ratio(input div_cfg_t c);
        if (c.bypass) return RATIO_W'(1);
        return RATIO_W'(eff_len(c.lo_cnt)) + RATIO_W'(eff_len(c.hi_cnt));
    endfunction

endpackage

// File: rtl/cdiv_stage.sv
module cdiv_stage
    import cdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  div_cfg_t cfg,
    input  logic     restart,
    input  logic     strobe_in,
    output logic     wave_out,
    output logic     tick_out
);
    logic             phase_hi;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             last;

    assign lim  = phase_hi ? eff_len(cfg.hi_cnt) : eff_len(cfg.lo_cnt);
    assign last = (cnt == lim - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_hi <= 1'b1;
            cnt      <= '0;
        end else if (strobe_in) begin
            if (last) begin
                cnt      <= '0;
                phase_hi <= ~phase_hi;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    assign wave_out = cfg.bypass ? strobe_in : phase_hi;
    assign tick_out = cfg.bypass ? strobe_in : (strobe_in && !phase_hi && last);
endmodule

// File: rtl/cdiv_lock.sv
module cdiv_lock #(
    parameter int LOCK_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic commit,
    output logic locked
);
    localparam int LW = $clog2(LOCK_CYC + 1);
    logic [LW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (commit)
            remain <= LW'(LOCK_CYC);
        else if (remain != '0)
            remain <= remain - LW'(1);
    end

    assign locked = (remain == '0);
endmodule

// File: rtl/cdiv_regs.sv
module cdiv_regs
    import cdiv_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_we,
    input  logic [DATA_W-1:0]       bus_wdata,
    input  logic                    locked,
    output logic [DATA_W-1:0]       bus_rdata,
    output div_cfg_t [N_STAGES-1:0] cfg_q,
    output logic                    commit
);
    reg_sel_e                sel;
    logic                    wr_div;
    logic [1:0]              idx;
    div_word_t               wword;
    div_cfg_t [N_STAGES-1:0] staged;
    div_cfg_t [N_STAGES-1:0] staged_nx;
    logic [DATA_W-1:0]       ratio_word;

    always_comb begin
        unique case (bus_addr[ADDR_W-1:2])
            (ADDR_W-2)'(0): sel = SEL_PRE;
            (ADDR_W-2)'(1): sel = SEL_LOOP;
            (ADDR_W-2)'(2): sel = SEL_POST;
            (ADDR_W-2)'(3): sel = SEL_RATIO;
            (ADDR_W-2)'(4): sel = SEL_STAT;
            default:        sel = SEL_NONE;
        endcase
    end

    assign idx    = sel[1:0];
    assign wword  = div_word_t'(bus_wdata);
    assign wr_div = bus_we && (sel == SEL_PRE || sel == SEL_LOOP || sel == SEL_POST);
    assign commit = wr_div && !wword.hold;

    always_comb begin
        staged_nx = staged;
        if (wr_div) staged_nx[idx] = word_to_cfg(bus_wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_STAGES; i++) begin
                staged[i] <= CFG_RESET;
                cfg_q[i]  <= CFG_RESET;
            end
        end else begin
            staged <= staged_nx;
            if (commit) cfg_q <= staged_nx;
        end
    end

    generate
        for (genvar g = 0; g < N_STAGES; g++) begin : g_lane
            assign ratio_word[g*LANE_W +: LANE_W] = LANE_W'(eff_ratio(cfg_q[g]));
        end
        if (N_STAGES * LANE_W < DATA_W) begin : g_pad
            assign ratio_word[DATA_W-1:N_STAGES*LANE_W] = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else begin
            unique case (sel)
                SEL_PRE, SEL_LOOP, SEL_POST: bus_rdata <= cfg_to_word(cfg_q[idx]);
                SEL_RATIO:                   bus_rdata <= ratio_word;
                SEL_STAT:                    bus_rdata <= {{(DATA_W-1){1'b0}}, locked};
                default:                     bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/cdiv_top.sv
module cdiv_top
    import cdiv_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int LOCK_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              div_out,
    output logic              half_adj
);
    div_cfg_t [N_STAGES-1:0] cfg_q;
    logic                    commit;
    logic                    locked;
    logic [N_STAGES:0]       strobe;
    logic [N_STAGES-1:0]     wave;

    cdiv_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .locked    (locked),
        .bus_rdata (bus_rdata),
        .cfg_q     (cfg_q),
        .commit    (commit)
    );

    cdiv_lock #(.LOCK_CYC(LOCK_CYC)) u_lock (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .locked (locked)
    );

    assign strobe[0] = 1'b1;

    generate
        for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
            cdiv_stage u_stage (
                .clk       (clk),
                .rst       (rst),
                .cfg       (cfg_q[s]),
                .restart   (commit),
                .strobe_in (strobe[s]),
                .wave_out  (wave[s]),
                .tick_out  (strobe[s+1])
            );
        end
    endgenerate

    assign div_out  = wave[N_STAGES-1];
    assign half_adj = cfg_q[N_STAGES-1].align && !cfg_q[N_STAGES-1].bypass;
endmodule

// File: rtl/cdiv_chk.sv
module cdiv_chk
    import cdiv_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    commit,
    input logic                    locked,
    input logic                    half_adj,
    input logic                    bus_we,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [31:0]             bus_wdata,
    input logic [31:0]             bus_rdata,
    input div_cfg_t [N_STAGES-1:0] cfg_q
);
    logic div_hit;
    assign div_hit = (bus_addr[ADDR_W-1:2] < (ADDR_W-2)'(3));

    // R8: the status drops right after a commit
    a_r8_unlock_after_commit: assert property (@(posedge clk) disable iff (rst)
        commit |=> !locked);

    // R9: relock never follows a cycle that committed
    a_r9_no_relock_on_commit: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> !$past(commit));

    // R6: a held write leaves committed settings alone
    a_r6_hold_inert: assert property (@(posedge clk) disable iff (rst)
        (bus_we && div_hit && bus_wdata[14]) |=> $stable(cfg_q));

    // R1: divider reads return zero in hold and reserved bits
    a_r1_unused_zero: assert property (@(posedge clk) disable iff (rst)
        div_hit |=> (bus_rdata[31:14] == '0));

    // R4: alignment request only on a dividing post stage
    a_r4_align_live: assert property (@(posedge clk) disable iff (rst)
        half_adj |-> !cfg_q[N_STAGES-1].bypass);
endmodule

bind cdiv_top cdiv_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .commit    (commit),
    .locked    (locked),
    .half_adj  (half_adj),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg_q     (cfg_q)
);

// File: tb/tb_cdiv_top.sv
module tb_cdiv_top;
    localparam int CLK_PERIOD = 10;
    localparam int LOCK_CYC   = 16;

    localparam logic [7:0] A_PRE = 8'h00, A_LOOP = 8'h04, A_POST = 8'h08,
                           A_RAT = 8'h0C, A_STAT = 8'h10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        div_out;
    logic        half_adj;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cdiv_top #(.ADDR_W(8), .LOCK_CYC(LOCK_CYC)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .div_out(div_out), .half_adj(half_adj)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the write edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_we = 1'b0;
        @(posedge clk); @(negedge clk);
        d = bus_rdata;
    endtask

    // Counts clocks from the commit edge until status reads 1.
    task automatic lock_wait(output int k);
        bus_addr = A_STAT;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (bus_rdata[0] !== 1'b1 && k < 200);
    endtask

    task automatic measure(output int hi, output int lo);
        int guard;
        hi = 0; lo = 0; guard = 0;
        while (div_out !== 1'b0 && guard < 500) begin @(negedge clk); guard++; end
        while (div_out !== 1'b1 && guard < 500) begin @(negedge clk); guard++; end
        while (div_out === 1'b1 && guard < 500) begin hi++; @(negedge clk); guard++; end
        while (div_out === 1'b0 && guard < 500) begin lo++; @(negedge clk); guard++; end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R2 div_out", div_out, 1);
        rd(A_PRE, d);  check("R2 pre word", d, 32'h2000);
        rd(A_POST, d); check("R2 post word", d, 32'h2000);
        rd(A_RAT, d);  check("R2 ratio word", d, 32'h00010101);
        rd(A_STAT, d); check("R2 status", d, 1);
        rd(8'h14, d);  check("R1 unmapped reads zero", d, 0);
    endtask

    task automatic t_even();
        logic [31:0] d; int k, hi, lo;
        wr(A_POST, 32'h0000_0082);
        lock_wait(k); check("R8 relock clocks", k, LOCK_CYC + 1);
        measure(hi, lo);
        check("R3 even high run", hi, 2); check("R3 even low run", lo, 2);
        rd(A_POST, d); check("R1 post readback", d, 32'h082);
        rd(A_RAT, d);  check("R11 ratio even", d, 32'h00040101);
        check("R4 no align on even", half_adj, 0);
    endtask

    task automatic t_odd();
        logic [31:0] d; int hi, lo;
        wr(A_POST, 32'h0000_1083);
        measure(hi, lo);
        check("R4 odd high run", hi, 2); check("R4 odd low run", lo, 3);
        check("R4 align flag", half_adj, 1);
        rd(A_RAT, d); check("R11 ratio odd", d, 32'h00050101);
    endtask

    task automatic t_restart();
        int k;
        wr(A_POST, 32'h0000_0082);
        repeat (5) @(negedge clk);
        wr(A_POST, 32'h0000_0082);
        lock_wait(k); check("R9 restarted interval", k, LOCK_CYC + 1);
    endtask

    task automatic t_stage();
        logic [31:0] d; int hi, lo;
        wr(A_POST, 32'h0000_40C3);
        rd(A_STAT, d); check("R6 status stays locked", d, 1);
        rd(A_POST, d); check("R6 post unchanged", d, 32'h082);
        measure(hi, lo);
        check("R6 high run kept", hi, 2); check("R6 low run kept", lo, 2);
        wr(A_PRE, 32'h0000_3001);
        rd(A_POST, d); check("R7 staged post committed", d, 32'h0C3);
        measure(hi, lo);
        check("R7 high run", hi, 3); check("R7 low run", lo, 3);
    endtask

    task automatic t_bypass();
        logic [31:0] d; int hi, lo;
        wr(A_POST, 32'h0000_7001);
        wr(A_PRE, 32'h0000_0082);
        measure(hi, lo);
        check("R5 passthrough high", hi, 1); check("R5 passthrough low", lo, 3);
        rd(A_PRE, d); check("R1 pre readback", d, 32'h082);
    endtask

    task automatic t_chain();
        logic [31:0] d; int hi, lo;
        wr(A_POST, 32'h0000_5042);
        wr(A_PRE, 32'h0000_0041);
        measure(hi, lo);
        check("R12 chained high", hi, 2); check("R12 chained low", lo, 4);
        rd(A_RAT, d); check("R11 ratio chained", d, 32'h00030102);
    endtask

    task automatic t_zero();
        logic [31:0] d; int hi, lo;
        wr(A_PRE, 32'h0000_7001);
        wr(A_POST, 32'h0000_0000);
        measure(hi, lo);
        check("R10 zero high", hi, 1); check("R10 zero low", lo, 1);
        rd(A_RAT, d); check("R10 zero ratio", d, 32'h00020101);
        rd(A_PRE, d); check("R1 hold bit reads zero", d, 32'h3001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_even();
        t_odd();
        t_restart();
        t_stage();
        t_bypass();
        t_chain();
        t_zero();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule